// File: doc/BRIEF.md
# Compact Arithmetic Halfword Decoder

This block turns one 16-bit compressed arithmetic instruction into an execution request for a 32-register integer core. It reads the instruction halfword and the address it was fetched from, and produces the full 5-bit register numbers of the destination and two sources, an operation select, a 32-bit immediate with a flag that picks it over the second register, a write enable, and two exception flags. It has no register file, ALU or multiplier of its own.

Four major opcode groups are recognised: an add-immediate to the stack pointer, an add-immediate group with a short-register and a full-register form, a three-register add/subtract, and a two-operand add/multiply with 4-bit register codes whose bits are scattered across the halfword. Short register codes expand through fixed non-linear maps. Every other major opcode passes through as a no-operation with no exception. Decode is combinational and is captured by one register stage. The stage updates only when an input is offered.

Top module: `dec16_arith`

## Requirements
- R1: Outputs come from one register stage. `outValid` equals the previous cycle's `inValid`. All other outputs load only when `inValid` is 1 and hold otherwise. Reset clears every output to 0.
- R2: A 3-bit register code c expands to 16+c for c in 0..3 and to c for c in 4..7.
- R3: A 4-bit register code c expands to 8+c for c in 0..3, to c for c in 4..7, and to c+8 for c in 8..15.
- R4: When `fetchAddr[0]` is 1, `excMisalign` is 1, `badAddr` is `fetchAddr`, and `wrEn` and `excReserved` are 0. All other decoded fields are 0, whatever the opcode. Otherwise `badAddr` is 0.
- R5: Opcode 6'b011100 (bits [15:10]) with bit 6 = 0: destination = 3-bit code at [9:7], source A = 29, immediate = zero-extended [5:0]×4, add, write.
- R6: Opcode 6'b011100 with bit 6 = 1 raises `excReserved` and does not write.
- R7: Opcode 6'b100100 with bit 3 = 0: destination = 3-bit code [9:7], source A = 3-bit code [6:4], immediate = zero-extended [2:0]×4, add, write.
- R8: Opcode 6'b100100 with bit 3 = 1: destination = source A = bits [9:5] unmapped, immediate = sign-extended 4-bit {bit 4, bits [2:0]}, add, write. A zero register number gives a no-operation with every field 0.
- R9: Opcode 6'b101100: destination = 3-bit code [3:1], source A = 3-bit code [6:4], source B = 3-bit code [9:7], no immediate, write. Bit 0 picks add (0) or subtract (1).
- R10: Opcode 6'b111100: the 4-bit codes {bit 9, [7:5]} and {bit 4, [2:0]} give destination = source B and source A. Sub-op {bit 8, bit 3} = 00 is add and 10 is multiply. Both write.
- R11: Opcode 6'b111100 with sub-op 01 or 11 raises `excReserved` and does not write.
- R12: Any other opcode gives all fields 0 and no exception.
- R13: `excMisalign` and `excReserved` are never both 1. `aluOp` codes: 0 add, 1 subtract, 2 multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction offered this cycle |
| instr | input | 16 | Instruction halfword |
| fetchAddr | input | 32 | Fetch address of the halfword |
| outValid | output | 1 | Registered request valid |
| dstIdx | output | 5 | Destination register number |
| srcAIdx | output | 5 | First source register number |
| srcBIdx | output | 5 | Second source register number |
| aluOp | output | 2 | 0 add, 1 subtract, 2 multiply |
| immVal | output | 32 | Extended immediate |
| useImm | output | 1 | Immediate replaces source B |
| wrEn | output | 1 | Destination write enable |
| excMisalign | output | 1 | Misaligned fetch exception |
| excReserved | output | 1 | Reserved instruction exception |
| badAddr | output | 32 | Faulting address on misaligned fetch |

## Verification
The hardest case to reach is a misaligned address that arrives together with an encoding that is itself reserved. Only then does the priority between the two exceptions show. The stimulus pairs odd fetch addresses with the reserved stack-pointer form and the reserved 4x4 sub-ops, so that the misaligned flag alone must appear. The scattered 4x4 fields are swept over all sixteen codes in both register positions, so every map entry is seen through the gathered bits.

// File: rtl/dec16_pkg.sv
package dec16_pkg;

  localparam int REG_W = 5;

  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2} aluOp_e;
  typedef enum logic [2:0] {DST_NONE, DST_RT3, DST_RD3, DST_R5, DST_RT4} dstSel_e;
  typedef enum logic [2:0] {SA_NONE, SA_SP, SA_RS3, SA_R5, SA_RS4} srcASel_e;
  typedef enum logic [1:0] {SB_NONE, SB_RT3, SB_RT4} srcBSel_e;
  typedef enum logic [1:0] {IMM_NONE, IMM_SP6, IMM_U3, IMM_S4} immSel_e;

  typedef struct packed {
    dstSel_e  dst;
    srcASel_e srcA;
    srcBSel_e srcB;
    immSel_e  imm;
    aluOp_e   op;
    logic     wr;
    logic     excMis;
    logic     excRsv;
  } decStrobe_t;

  // 3-bit code: 0..3 -> 16..19, 4..7 -> 4..7
  function automatic logic [REG_W-1:0] expand3(input logic [2:0] code);
    return code[2] ? {2'b00, code} : {2'b10, code};
  endfunction

  // 4-bit code: 0..3 -> 8..11, 4..7 -> 4..7, 8..15 -> 16..23
  function automatic logic [REG_W-1:0] expand4(input logic [3:0] code);
    if (code[3])      return {2'b10, code[2:0]};
    else if (code[2]) return {1'b0, code};
    else              return {2'b01, code[2:0]};
  endfunction

endpackage

// File: rtl/dec16_ctrl.sv
module dec16_ctrl
  import dec16_pkg::*;
#(
  parameter logic [5:0] OPC_SP     = 6'b011100,
  parameter logic [5:0] OPC_ADDI   = 6'b100100,
  parameter logic [5:0] OPC_ADDSUB = 6'b101100,
  parameter logic [5:0] OPC_4X4    = 6'b111100
) (
  input  logic [15:0] instr,
  input  logic        addrLsb,
  output decStrobe_t  strb
);

  logic [5:0] majorOpc;
  logic [1:0] subOp4;
  logic       unusedBits;

  assign majorOpc   = instr[15:10];
  assign subOp4     = {instr[8], instr[3]};
  assign unusedBits = ^{instr[4], instr[2:1]};

  always_comb begin
    strb = '{dst: DST_NONE, srcA: SA_NONE, srcB: SB_NONE, imm: IMM_NONE,
             op: OP_ADD, wr: 1'b0, excMis: 1'b0, excRsv: 1'b0};
    if (addrLsb) begin
      strb.excMis = 1'b1;
    end else begin
      case (majorOpc)
        OPC_SP: begin
          if (!instr[6]) begin
            strb.dst  = DST_RT3;
            strb.srcA = SA_SP;
            strb.imm  = IMM_SP6;
            strb.wr   = 1'b1;
          end else begin
            strb.excRsv = 1'b1;
          end
        end
        OPC_ADDI: begin
          if (!instr[3]) begin
            strb.dst  = DST_RT3;
            strb.srcA = SA_RS3;
            strb.imm  = IMM_U3;
            strb.wr   = 1'b1;
          end else if (instr[9:5] != '0) begin
            strb.dst  = DST_R5;
            strb.srcA = SA_R5;
            strb.imm  = IMM_S4;
            strb.wr   = 1'b1;
          end
        end
        OPC_ADDSUB: begin
          strb.dst  = DST_RD3;
          strb.srcA = SA_RS3;
          strb.srcB = SB_RT3;
          strb.op   = instr[0] ? OP_SUB : OP_ADD;
          strb.wr   = 1'b1;
        end
        OPC_4X4: begin
          case (subOp4)
            2'b00, 2'b10: begin
              strb.dst  = DST_RT4;
              strb.srcA = SA_RS4;
              strb.srcB = SB_RT4;
              strb.op   = subOp4[1] ? OP_MUL : OP_ADD;
              strb.wr   = 1'b1;
            end
            default: strb.excRsv = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dec16_dpath.sv
module dec16_dpath
  import dec16_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int SP_IDX = 29,
  parameter int RT_LSB = 7,
  parameter int RS_LSB = 4,
  parameter int RD_LSB = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [9:0]       fieldBits,
  input  logic [XLEN-1:0]  fetchAddr,
  input  decStrobe_t       strb,
  output logic             outValid,
  output logic [REG_W-1:0] dstIdx,
  output logic [REG_W-1:0] srcAIdx,
  output logic [REG_W-1:0] srcBIdx,
  output logic [1:0]       aluOp,
  output logic [XLEN-1:0]  immVal,
  output logic             useImm,
  output logic             wrEn,
  output logic             excMisalign,
  output logic             excReserved,
  output logic [XLEN-1:0]  badAddr
);

  localparam logic [REG_W-1:0] SP_REG = REG_W'(SP_IDX);

  logic [2:0]       rt3, rs3, rd3;
  logic [3:0]       rt4, rs4;
  logic [REG_W-1:0] r5;
  logic [REG_W-1:0] dstNxt, srcANxt, srcBNxt;
  logic [XLEN-1:0]  immNxt, badNxt;

  assign rt3 = fieldBits[RT_LSB +: 3];
  assign rs3 = fieldBits[RS_LSB +: 3];
  assign rd3 = fieldBits[RD_LSB +: 3];
  assign rt4 = {fieldBits[9], fieldBits[7:5]};
  assign rs4 = {fieldBits[4], fieldBits[2:0]};
  assign r5  = fieldBits[9:5];

  always_comb begin
    case (strb.dst)
      DST_RT3: dstNxt = expand3(rt3);
      DST_RD3: dstNxt = expand3(rd3);
      DST_R5:  dstNxt = r5;
      DST_RT4: dstNxt = expand4(rt4);
      default: dstNxt = '0;
    endcase
    case (strb.srcA)
      SA_SP:   srcANxt = SP_REG;
      SA_RS3:  srcANxt = expand3(rs3);
      SA_R5:   srcANxt = r5;
      SA_RS4:  srcANxt = expand4(rs4);
      default: srcANxt = '0;
    endcase
    case (strb.srcB)
      SB_RT3:  srcBNxt = expand3(rt3);
      SB_RT4:  srcBNxt = expand4(rt4);
      default: srcBNxt = '0;
    endcase
    case (strb.imm)
      IMM_SP6: immNxt = XLEN'({fieldBits[5:0], 2'b00});
      IMM_U3:  immNxt = XLEN'({fieldBits[2:0], 2'b00});
      IMM_S4:  immNxt = XLEN'($signed({fieldBits[4], fieldBits[2:0]}));
      default: immNxt = '0;
    endcase
    badNxt = strb.excMis ? fetchAddr : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      dstIdx      <= '0;
      srcAIdx     <= '0;
      srcBIdx     <= '0;
      aluOp       <= '0;
      immVal      <= '0;
      useImm      <= 1'b0;
      wrEn        <= 1'b0;
      excMisalign <= 1'b0;
      excReserved <= 1'b0;
      badAddr     <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        dstIdx      <= dstNxt;
        srcAIdx     <= srcANxt;
        srcBIdx     <= srcBNxt;
        aluOp       <= strb.op;
        immVal      <= immNxt;
        useImm      <= (strb.imm != IMM_NONE);
        wrEn        <= strb.wr;
        excMisalign <= strb.excMis;
        excReserved <= strb.excRsv;
        badAddr     <= badNxt;
      end
    end
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(dstIdx) && $stable(immVal) && $stable(wrEn) && $stable(badAddr));

  // R4
  misalign_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && fetchAddr[0] |=> excMisalign && !excReserved && !wrEn
                                && badAddr == $past(fetchAddr));

  // R13
  single_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excMisalign, excReserved}));

  // R6
  reserved_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReserved |-> !wrEn);

  // R8
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> dstIdx != '0);

  // R10
  mul_two_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    aluOp == 2'd2 |-> !useImm && dstIdx == srcBIdx);

endmodule

// File: rtl/dec16_arith.sv
module dec16_arith
  import dec16_pkg::*;
#(
  parameter int         XLEN       = 32,
  parameter int         SP_IDX     = 29,
  parameter int         RT_LSB     = 7,
  parameter int         RS_LSB     = 4,
  parameter int         RD_LSB     = 1,
  parameter logic [5:0] OPC_SP     = 6'b011100,
  parameter logic [5:0] OPC_ADDI   = 6'b100100,
  parameter logic [5:0] OPC_ADDSUB = 6'b101100,
  parameter logic [5:0] OPC_4X4    = 6'b111100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [15:0]     instr,
  input  logic [XLEN-1:0] fetchAddr,
  output logic            outValid,
  output logic [4:0]      dstIdx,
  output logic [4:0]      srcAIdx,
  output logic [4:0]      srcBIdx,
  output logic [1:0]      aluOp,
  output logic [XLEN-1:0] immVal,
  output logic            useImm,
  output logic            wrEn,
  output logic            excMisalign,
  output logic            excReserved,
  output logic [XLEN-1:0] badAddr
);

  decStrobe_t strb;

  dec16_ctrl #(
    .OPC_SP(OPC_SP), .OPC_ADDI(OPC_ADDI),
    .OPC_ADDSUB(OPC_ADDSUB), .OPC_4X4(OPC_4X4)
  ) u_ctrl (
    .instr   (instr),
    .addrLsb (fetchAddr[0]),
    .strb    (strb)
  );

  dec16_dpath #(
    .XLEN(XLEN), .SP_IDX(SP_IDX),
    .RT_LSB(RT_LSB), .RS_LSB(RS_LSB), .RD_LSB(RD_LSB)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .fieldBits   (instr[9:0]),
    .fetchAddr   (fetchAddr),
    .strb        (strb),
    .outValid    (outValid),
    .dstIdx      (dstIdx),
    .srcAIdx     (srcAIdx),
    .srcBIdx     (srcBIdx),
    .aluOp       (aluOp),
    .immVal      (immVal),
    .useImm      (useImm),
    .wrEn        (wrEn),
    .excMisalign (excMisalign),
    .excReserved (excReserved),
    .badAddr     (badAddr)
  );

endmodule

// File: tb/dec16_arith_bench.sv
module dec16_arith_bench;

  localparam logic [5:0] OP_SPA = 6'b011100;
  localparam logic [5:0] OP_AIM = 6'b100100;
  localparam logic [5:0] OP_ASB = 6'b101100;
  localparam logic [5:0] OP_Q44 = 6'b111100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] fetchAddr = '0;
  logic        outValid;
  logic [4:0]  dstIdx, srcAIdx, srcBIdx;
  logic [1:0]  aluOp;
  logic [31:0] immVal, badAddr;
  logic        useImm, wrEn, excMisalign, excReserved;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  dec16_arith u_dec16_arith (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .fetchAddr(fetchAddr),
    .outValid(outValid), .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .aluOp(aluOp), .immVal(immVal), .useImm(useImm), .wrEn(wrEn),
    .excMisalign(excMisalign), .excReserved(excReserved), .badAddr(badAddr)
  );

  // expected-value layout: {valid, dst, a, b, op, useImm, wr, mis, rsv, imm, bad}
  function automatic logic [85:0] actual();
    return {outValid, dstIdx, srcAIdx, srcBIdx, aluOp, useImm, wrEn,
            excMisalign, excReserved, immVal, badAddr};
  endfunction

  function automatic logic [4:0] map3(input logic [2:0] c);
    logic [4:0] tbl [8] = '{5'd16, 5'd17, 5'd18, 5'd19, 5'd4, 5'd5, 5'd6, 5'd7};
    return tbl[c];
  endfunction

  function automatic logic [4:0] map4(input logic [3:0] c);
    logic [4:0] tbl [16] = '{5'd8, 5'd9, 5'd10, 5'd11, 5'd4, 5'd5, 5'd6, 5'd7,
                             5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23};
    return tbl[c];
  endfunction

  function automatic logic [85:0] model(input logic [15:0] ins, input logic [31:0] adr);
    logic [4:0] d = 0, a = 0, b = 0;
    logic [1:0] op = 0;
    logic ui = 0, wr = 0, mis = 0, rsv = 0;
    logic [31:0] im = 0, bad = 0;
    if (adr[0]) begin
      mis = 1; bad = adr;
    end else if (ins[15:10] == OP_SPA) begin
      if (ins[6]) rsv = 1;
      else begin d = map3(ins[9:7]); a = 5'd29; im = {24'd0, ins[5:0], 2'b00}; ui = 1; wr = 1; end
    end else if (ins[15:10] == OP_AIM) begin
      if (!ins[3]) begin
        d = map3(ins[9:7]); a = map3(ins[6:4]); im = {27'd0, ins[2:0], 2'b00}; ui = 1; wr = 1;
      end else if (ins[9:5] != 0) begin
        d = ins[9:5]; a = ins[9:5]; ui = 1; wr = 1;
        im = ins[4] ? (32'hFFFF_FFF8 | ins[2:0]) : {29'd0, ins[2:0]};
      end
    end else if (ins[15:10] == OP_ASB) begin
      d = map3(ins[3:1]); a = map3(ins[6:4]); b = map3(ins[9:7]); op = {1'b0, ins[0]}; wr = 1;
    end else if (ins[15:10] == OP_Q44) begin
      if (ins[3]) rsv = 1;
      else begin
        d = map4({ins[9], ins[7:5]}); b = d; a = map4({ins[4], ins[2:0]});
        op = ins[8] ? 2'd2 : 2'd0; wr = 1;
      end
    end
    return {1'b1, d, a, b, op, ui, wr, mis, rsv, im, bad};
  endfunction

  task automatic check(input string tag, input logic [85:0] act, input logic [85:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; leaves at the negedge after the capture edge
  task automatic issue(input string tag, input logic [15:0] ins, input logic [31:0] adr);
    instr = ins; fetchAddr = adr; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, actual(), model(ins, adr));
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic testReset();
    check("R1 reset state", actual(), 86'd0);
  endtask

  task automatic testSpAdd();
    for (int c = 0; c < 8; c++)
      issue("R5 R2 sp add", {OP_SPA, c[2:0], 1'b0, 6'(c * 9 + 1)}, 32'h100);
    issue("R5 max imm", {OP_SPA, 3'd5, 1'b0, 6'h3F}, 32'h102);
    issue("R6 sp reserved", {OP_SPA, 3'd2, 1'b1, 6'h15}, 32'h104);
  endtask

  task automatic testAddImm();
    for (int c = 0; c < 8; c++)
      issue("R7 R2 two-reg add imm", {OP_AIM, c[2:0], 3'(7 - c), 1'b0, c[2:0]}, 32'h200);
    issue("R8 positive imm", {OP_AIM, 5'd13, 1'b0, 1'b1, 3'd7}, 32'h204);
    issue("R8 negative imm", {OP_AIM, 5'd31, 1'b1, 1'b1, 3'd0}, 32'h206);
    issue("R8 minus one", {OP_AIM, 5'd1, 1'b1, 1'b1, 3'd7}, 32'h208);
    issue("R8 zero reg nop", {OP_AIM, 5'd0, 1'b1, 1'b1, 3'd5}, 32'h20A);
  endtask

  task automatic testAddSub();
    for (int c = 0; c < 8; c++) begin
      issue("R9 add", {OP_ASB, c[2:0], 3'(c + 3), 3'(c + 5), 1'b0}, 32'h300);
      issue("R9 sub", {OP_ASB, 3'(c + 1), c[2:0], 3'(6 - c), 1'b1}, 32'h302);
    end
  endtask

  task automatic testQuad();
    for (int c = 0; c < 16; c++) begin
      logic [3:0] rt = c[3:0], rs = 4'(15 - c);
      issue("R10 R3 add", {OP_Q44, rt[3], 1'b0, rt[2:0], rs[3], 1'b0, rs[2:0]}, 32'h400);
      issue("R10 R3 mul", {OP_Q44, rs[3], 1'b1, rs[2:0], rt[3], 1'b0, rt[2:0]}, 32'h402);
    end
    issue("R11 subop 01", {OP_Q44, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 3'd4}, 32'h404);
    issue("R11 subop 11", {OP_Q44, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 3'd1}, 32'h406);
  endtask

  task automatic testMisalign();
    issue("R4 misaligned add", {OP_ASB, 3'd1, 3'd2, 3'd3, 1'b0}, 32'h8000_0001);
    issue("R4 R13 over sp reserved", {OP_SPA, 3'd1, 1'b1, 6'h01}, 32'h0000_0FFF);
    issue("R4 R13 over quad reserved", {OP_Q44, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 3'd1}, 32'hDEAD_BEEF);
    issue("R4 misaligned other", 16'h0000, 32'h0000_0003);
    issue("R4 aligned clears bad", {OP_SPA, 3'd0, 1'b0, 6'h01}, 32'h0000_0010);
  endtask

  task automatic testOther();
    issue("R12 opcode 0", 16'h03FF, 32'h500);
    issue("R12 opcode 110100", {6'b110100, 10'h2AB}, 32'h502);
    issue("R12 opcode 011101", {6'b011101, 10'h001}, 32'h504);
  endtask

  task automatic testHold();
    logic [85:0] snap;
    issue("R1 load", {OP_ASB, 3'd4, 3'd5, 3'd6, 1'b1}, 32'h600);
    snap = actual();
    instr = {OP_SPA, 3'd2, 1'b0, 6'h11}; fetchAddr = 32'h1; inValid = 1'b0;
    @(negedge clk);
    check("R1 hold while idle", actual(), {1'b0, snap[84:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSpAdd();
    testAddImm();
    testAddSub();
    testQuad();
    testMisalign();
    testOther();
    testHold();
    finishRun();
  end

endmodule